// File: doc/BRIEF.md
# Vectored Interrupt Controller with Delayed Enable

This block collects eight interrupt events for a small 4-bit processor core and turns them into vectored requests. Two external pins are watched for a selectable edge. Six single-cycle internal pulses also feed the block: four timer underflows, one converter-done pulse and one serial-done pulse. Every event sets a request flag, and each flag is qualified by a per-source enable bit and one global enable.

The core reports instruction boundaries and the enable, disable and return-from-interrupt instructions through one-cycle strobes. At a boundary where the global enable is on and an enabled request is pending, the block picks the highest-priority source. It then pulses `takeIrq` together with the vector address. The core uses that pulse to push its return address and to save its data pointer, carry, skip flag and working registers to the interrupt context store. In the same step the block clears the global enable and the serviced source's flag. A return strobe produces a one-cycle context-restore pulse.

An enable instruction does not act at once. It takes effect only when the instruction after it completes. An enable placed directly before a return therefore admits interrupts only once control is back in the interrupted code.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `takeIrq`, `restoreCtx` and `globalEn` are 0, `reqFlags` is all zero and `vecAddr` is 0.
- R2: A source event sets its bit in `reqFlags` one clock later, whatever the enables are. The bit then stays set until that source is serviced or cleared through `srcClr`.
- R3: External source n (n = 0, 1) is raised by a rising edge of `extPin[n]` when `extRise[n]` is 1, and by a falling edge when it is 0. An edge of the other direction has no effect.
- R4: An `eiStrobe` sets `globalEn` only when a later cycle with `instrDone` occurs. Interrupts can be accepted at that later boundary, but not at the boundary on which the enable instruction itself completed.
- R5: Accepting an interrupt clears `globalEn`.
- R6: Accepting an interrupt clears only the serviced source's flag; every other flag keeps its value.
- R7: The vector equals `VEC_BASE + 2*index`. Index 0 and 1 are the external pins, 2 to 5 are timers 1 to 4, 6 is the converter and 7 is the serial unit, so the default vectors are 0x80, 0x82 … 0x8E.
- R8: When several enabled requests are pending, the lowest index is serviced. A request whose `srcEnable` bit is 0 is never accepted.
- R9: Acceptance happens only in a cycle with `instrDone`. `takeIrq` is a one-cycle pulse in the following cycle, with `vecAddr` valid in the same cycle.
- R10: `diStrobe` clears `globalEn` and cancels any pending enable, so no interrupt is accepted in that cycle or at later boundaries until a new enable takes effect.
- R11: `rtiStrobe` gives a one-cycle `restoreCtx` pulse in the following cycle and leaves `globalEn` unchanged. An enable placed just before it admits an interrupt at the return boundary itself.
- R12: A 1 on `srcClr[n]` clears flag n. If an event for source n arrives in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extPin | input | NUM_EXT | External interrupt pin levels |
| extRise | input | NUM_EXT | Edge select per pin: 1 rising, 0 falling |
| intEvt | input | NUM_SRC-NUM_EXT | Internal event pulses, bit k is source index k+NUM_EXT |
| srcEnable | input | NUM_SRC | Per-source enable bits |
| srcClr | input | NUM_SRC | Per-source flag clear pulses |
| instrDone | input | 1 | Instruction-complete strobe from the core |
| eiStrobe | input | 1 | Enable-interrupts instruction strobe |
| diStrobe | input | 1 | Disable-interrupts instruction strobe |
| rtiStrobe | input | 1 | Return-from-interrupt instruction strobe |
| takeIrq | output | 1 | Take-interrupt pulse: push return address, save context, jump to vecAddr |
| vecAddr | output | ADDR_W | Vector address of the accepted source |
| restoreCtx | output | 1 | Context restore pulse after a return |
| globalEn | output | 1 | Global interrupt enable flag |
| reqFlags | output | NUM_SRC | Pending request flags |

## Verification
Every result of this block is registered once. An event, a clear or an edge shows in `reqFlags` one clock after the cycle that drives it. `takeIrq` and `vecAddr` appear one clock after the accepting `instrDone`, and `restoreCtx` appears one clock after `rtiStrobe`. The bench drives each stimulus on a falling edge and checks on the next falling edge. Its driver task queues the expected vector before the accepting boundary is applied, and a monitor pops one entry from the queue on every `takeIrq` it sees. Any pulse for which no entry was queued is reported as a miscompare.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Control-to-datapath strobes for one clock cycle
  typedef struct packed {
    logic accept;   // take the winning request this cycle
    logic restore;  // return instruction completed
  } ctlStrobe_t;
endpackage

// File: rtl/irq_control.sv
module irq_control
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       eiStrobe,
  input  logic       diStrobe,
  input  logic       rtiStrobe,
  input  logic       instrDone,
  input  logic       anyReady,
  output logic       globalEn,
  output ctlStrobe_t strobe
);
  logic eiPending;
  logic eiMatures;
  logic enNow;

  // A waiting enable matures at the boundary after the enable instruction
  assign eiMatures = eiPending & instrDone & ~diStrobe;
  assign enNow     = globalEn | eiMatures;

  always_comb begin
    strobe.accept  = instrDone & ~diStrobe & enNow & anyReady;
    strobe.restore = rtiStrobe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      globalEn  <= 1'b0;
      eiPending <= 1'b0;
    end else if (diStrobe || strobe.accept) begin
      globalEn  <= 1'b0;
      eiPending <= 1'b0;
    end else begin
      if (eiMatures) globalEn <= 1'b1;
      eiPending <= eiStrobe | (eiPending & ~instrDone);
    end
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int NUM_EXT  = 2,
  parameter int ADDR_W   = 8,
  parameter int VEC_BASE = 'h80
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_EXT-1:0]         extPin,
  input  logic [NUM_EXT-1:0]         extRise,
  input  logic [NUM_SRC-NUM_EXT-1:0] intEvt,
  input  logic [NUM_SRC-1:0]         srcEnable,
  input  logic [NUM_SRC-1:0]         srcClr,
  input  ctlStrobe_t                 strobe,
  output logic                       anyReady,
  output logic [NUM_SRC-1:0]         reqFlags,
  output logic                       takeIrq,
  output logic [ADDR_W-1:0]          vecAddr,
  output logic                       restoreCtx
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(VEC_BASE);

  logic [NUM_EXT-1:0] pinPrev;
  logic [NUM_SRC-1:0] evtHit;
  logic [NUM_SRC-1:0] ready;
  logic [NUM_SRC-1:0] winner;
  logic [IDX_W-1:0]   winIdx;

  // Edge detectors on the external pins, direction chosen per pin
  for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
    assign evtHit[g] = extRise[g] ? (extPin[g] & ~pinPrev[g])
                                  : (~extPin[g] & pinPrev[g]);
  end
  assign evtHit[NUM_SRC-1:NUM_EXT] = intEvt;

  assign ready    = reqFlags & srcEnable;
  assign anyReady = |ready;

  // Fixed priority: lowest index wins
  always_comb begin
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (ready[i]) winIdx = IDX_W'(i);
    end
  end

  always_comb begin
    winner = '0;
    winner[winIdx] = strobe.accept;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinPrev    <= '0;
      reqFlags   <= '0;
      takeIrq    <= 1'b0;
      vecAddr    <= '0;
      restoreCtx <= 1'b0;
    end else begin
      pinPrev    <= extPin;
      // a new event beats any clear in the same cycle
      reqFlags   <= (reqFlags & ~srcClr & ~winner) | evtHit;
      takeIrq    <= strobe.accept;
      restoreCtx <= strobe.restore;
      if (strobe.accept) begin
        vecAddr <= BASE + ADDR_W'({winIdx, 1'b0});
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int NUM_EXT  = 2,
  parameter int ADDR_W   = 8,
  parameter int VEC_BASE = 'h80
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_EXT-1:0]         extPin,
  input  logic [NUM_EXT-1:0]         extRise,
  input  logic [NUM_SRC-NUM_EXT-1:0] intEvt,
  input  logic [NUM_SRC-1:0]         srcEnable,
  input  logic [NUM_SRC-1:0]         srcClr,
  input  logic                       instrDone,
  input  logic                       eiStrobe,
  input  logic                       diStrobe,
  input  logic                       rtiStrobe,
  output logic                       takeIrq,
  output logic [ADDR_W-1:0]          vecAddr,
  output logic                       restoreCtx,
  output logic                       globalEn,
  output logic [NUM_SRC-1:0]         reqFlags
);
  ctlStrobe_t strobe;
  logic       anyReady;

  irq_control i_control (
    .clk       (clk),
    .rstN      (rstN),
    .eiStrobe  (eiStrobe),
    .diStrobe  (diStrobe),
    .rtiStrobe (rtiStrobe),
    .instrDone (instrDone),
    .anyReady  (anyReady),
    .globalEn  (globalEn),
    .strobe    (strobe)
  );

  irq_datapath #(
    .NUM_SRC (NUM_SRC),
    .NUM_EXT (NUM_EXT),
    .ADDR_W  (ADDR_W),
    .VEC_BASE(VEC_BASE)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .extPin    (extPin),
    .extRise   (extRise),
    .intEvt    (intEvt),
    .srcEnable (srcEnable),
    .srcClr    (srcClr),
    .strobe    (strobe),
    .anyReady  (anyReady),
    .reqFlags  (reqFlags),
    .takeIrq   (takeIrq),
    .vecAddr   (vecAddr),
    .restoreCtx(restoreCtx)
  );
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int NUM_SRC  = 8,
  parameter int ADDR_W   = 8,
  parameter int VEC_BASE = 'h80
) (
  input logic              clk,
  input logic              rstN,
  input logic              instrDone,
  input logic              diStrobe,
  input logic              rtiStrobe,
  input logic              takeIrq,
  input logic [ADDR_W-1:0] vecAddr,
  input logic              restoreCtx,
  input logic              globalEn
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(VEC_BASE);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(2 * NUM_SRC);

  assert_enable_waits_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(globalEn) |-> $past(instrDone));

  assert_accept_disables_R5: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> !globalEn);

  assert_vector_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> (vecAddr - BASE) < SPAN);

  assert_take_at_boundary_R9: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> $past(instrDone));

  assert_take_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |=> !takeIrq);

  assert_disable_blocks_R10: assert property (@(posedge clk) disable iff (!rstN)
    diStrobe |=> (!globalEn && !takeIrq));

  assert_restore_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    rtiStrobe |=> restoreCtx);

  assert_enable_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!instrDone && !diStrobe) |=> $stable(globalEn));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
  .NUM_SRC (NUM_SRC),
  .ADDR_W  (ADDR_W),
  .VEC_BASE(VEC_BASE)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .instrDone (instrDone),
  .diStrobe  (diStrobe),
  .rtiStrobe (rtiStrobe),
  .takeIrq   (takeIrq),
  .vecAddr   (vecAddr),
  .restoreCtx(restoreCtx),
  .globalEn  (globalEn)
);

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  localparam logic [7:0] BASE = 8'h80;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] extPin = '0;
  logic [1:0] extRise = '0;
  logic [5:0] intEvt = '0;
  logic [7:0] srcEnable = '0;
  logic [7:0] srcClr = '0;
  logic       instrDone = 1'b0;
  logic       eiStrobe = 1'b0;
  logic       diStrobe = 1'b0;
  logic       rtiStrobe = 1'b0;
  logic       takeIrq;
  logic [7:0] vecAddr;
  logic       restoreCtx;
  logic       globalEn;
  logic [7:0] reqFlags;

  int checks = 0;
  int fails = 0;
  logic [7:0] expQ[$];

  always #10 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rstN(rstN), .extPin(extPin), .extRise(extRise), .intEvt(intEvt),
    .srcEnable(srcEnable), .srcClr(srcClr), .instrDone(instrDone),
    .eiStrobe(eiStrobe), .diStrobe(diStrobe), .rtiStrobe(rtiStrobe),
    .takeIrq(takeIrq), .vecAddr(vecAddr), .restoreCtx(restoreCtx),
    .globalEn(globalEn), .reqFlags(reqFlags)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    intEvt = '0; srcClr = '0; instrDone = 1'b0;
    eiStrobe = 1'b0; diStrobe = 1'b0; rtiStrobe = 1'b0;
  endtask

  // driver side of the scoreboard: queue the vector due after this boundary
  task automatic expectTake(input int idx);
    expQ.push_back(BASE + 8'(2 * idx));
  endtask

  // monitor: every take pulse must match the oldest queued vector (R7, R8, R9)
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && takeIrq) begin
        if (expQ.size() == 0) check(0, "R9 unexpected take", {24'd0, vecAddr}, 32'd0);
        else begin
          logic [7:0] e;
          e = expQ.pop_front();
          check(vecAddr == e, "R7/R8 vector", {24'd0, vecAddr}, {24'd0, e});
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    tick();
    // R1 reset state
    check(takeIrq == 0 && restoreCtx == 0, "R1 strobes", {takeIrq, restoreCtx}, 0);
    check(globalEn == 0, "R1 globalEn", globalEn, 0);
    check(reqFlags == 0 && vecAddr == 0, "R1 flags/vector", {reqFlags, vecAddr}, 0);

    // R3 edge select: pin0 rising, pin1 falling
    extRise = 2'b01;
    extPin = 2'b01; tick();
    check(reqFlags == 8'h01, "R3 pin0 rise", reqFlags, 8'h01);
    extPin = 2'b11; tick();
    check(reqFlags == 8'h01, "R3 pin1 rise ignored", reqFlags, 8'h01);
    extPin = 2'b01; tick();
    check(reqFlags == 8'h03, "R3 pin1 fall", reqFlags, 8'h03);
    extPin = 2'b00; tick();
    check(reqFlags == 8'h03, "R3 pin0 fall ignored", reqFlags, 8'h03);

    // R12 clear, and event beating a clear
    srcClr = 8'h02; tick();
    check(reqFlags == 8'h01, "R12 clear", reqFlags, 8'h01);
    intEvt = 6'b000001; srcClr = 8'h04; tick();
    check(reqFlags == 8'h05, "R12 event wins", reqFlags, 8'h05);

    // R2 flag held while disabled, boundaries pass with no take
    srcEnable = 8'hFE; instrDone = 1'b1; tick();
    instrDone = 1'b1; tick();
    check(reqFlags == 8'h05 && takeIrq == 0, "R2 held", reqFlags, 8'h05);

    // R4 enable delay
    eiStrobe = 1'b1; instrDone = 1'b1; tick();
    check(globalEn == 0 && takeIrq == 0, "R4 not yet", globalEn, 0);
    expectTake(2); instrDone = 1'b1; tick();
    check(globalEn == 0, "R5 cleared on accept", globalEn, 0);
    check(reqFlags == 8'h01, "R6 only serviced cleared", reqFlags, 8'h01);

    // R8 priority among enabled, idx0 masked
    intEvt = 6'b001010; tick();
    check(reqFlags == 8'h29, "R2 new events", reqFlags, 8'h29);
    eiStrobe = 1'b1; instrDone = 1'b1; tick();
    expectTake(3); instrDone = 1'b1; tick();
    check(reqFlags == 8'h21, "R6 others kept", reqFlags, 8'h21);

    // R9 acceptance only at instrDone
    srcEnable = 8'h00;
    eiStrobe = 1'b1; instrDone = 1'b1; tick();
    instrDone = 1'b1; tick();
    check(globalEn == 1, "R4 enabled after next", globalEn, 1);
    srcEnable = 8'hFF; tick(); tick(); tick();
    check(takeIrq == 0 && globalEn == 1, "R9 no boundary", takeIrq, 0);
    expectTake(0); instrDone = 1'b1; tick();
    check(reqFlags == 8'h20, "R8 lowest wins", reqFlags, 8'h20);

    // R10 disable cancels a waiting enable
    eiStrobe = 1'b1; instrDone = 1'b1; tick();
    diStrobe = 1'b1; instrDone = 1'b1; tick();
    instrDone = 1'b1; tick();
    check(globalEn == 0 && takeIrq == 0, "R10 cancelled", globalEn, 0);

    // R11 return alone, then enable just before return
    rtiStrobe = 1'b1; instrDone = 1'b1; tick();
    check(restoreCtx == 1 && globalEn == 0, "R11 restore", {restoreCtx, globalEn}, 2'b10);
    tick();
    check(restoreCtx == 0, "R11 single pulse", restoreCtx, 0);
    eiStrobe = 1'b1; instrDone = 1'b1; tick();
    expectTake(5); rtiStrobe = 1'b1; instrDone = 1'b1; tick();
    check(restoreCtx == 1 && reqFlags == 8'h00, "R11 take after return",
          {restoreCtx, reqFlags}, 9'h100);
    tick();
    check(expQ.size() == 0, "R9 missing take", expQ.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule